// File: doc/BRIEF.md
# Performance Monitoring Counter Unit

This block counts hardware activity for software profiling. It holds a parameterised number of 32-bit event counters, up to 31 of them, and one 64-bit cycle counter that always sits at counter index 31. Each event counter has a type register. The event number in that register picks the source of the counter's increments: one of the `evt_in` lines, or a software-increment register. Software reaches all state through a single synchronous register port. Writes take effect at the clock edge. Reads are combinational from `addr`.

A selector register chooses which counter the indirect value and type addresses reach. A global control register holds these controls:
- a global enable,
- one-shot resets, one for the event counters and one for the cycle counter,
- a divide-by-64 prescaler for the cycle counter,
- a long overflow mode.

Count-enable, interrupt-enable and overflow-status each have a write-one-to-set address and a write-one-to-clear address. A counter that wraps sets its status bit. The level interrupt is high while any status bit is set whose interrupt-enable bit is also set.

The cycle counter is driven by a small mode machine with three states:
- `CYC_HALT`: the counter holds.
- `CYC_FULL`: the counter advances every clock.
- `CYC_PRESCALE`: the counter advances once per 64 clocks, timed by a 6-bit remainder count.

Every clock the machine takes one of three transitions, from any state:
- halt: to `CYC_HALT` when the global enable or count-enable bit 31 is clear.
- full: to `CYC_FULL` when both are set and the divide bit is clear.
- prescale: to `CYC_PRESCALE` when both are set and the divide bit is set.

Because the state is registered, a mode change reaches the cycle counter one clock after the control write.

Top module: `perf_mon_unit`

## Requirements
- R1: No counter advances while control bit 0 (global enable) is 0. An event counter advances on a clock where its selected event is present and both the global enable and its own count-enable bit are 1.
- R2: Count-enable is written with write-one-to-set at address 2 and write-one-to-clear at address 3. Both addresses read back the current mask. Bit i belongs to counter i, and bit 31 belongs to the cycle counter.
- R3: Writing control (address 0) with bit 1 set zeroes every event counter and leaves the cycle counter unchanged. The bit reads back as 0.
- R4: Writing control with bit 2 set zeroes the cycle counter only. The bit reads back as 0.
- R5: With control bit 3 set, the cycle counter advances exactly once per 64 clocks. With control bit 3 clear, it advances once per clock.
- R6: With control bit 6 clear, a cycle-counter overflow is flagged when the low 32 bits wrap, and the 64-bit count carries on. With control bit 6 set, an overflow is flagged only when the full 64-bit value wraps.
- R7: Control reads as {implementer code [31:24], id code [23:16], number of event counters [15:11], zeros, bit 6, bit 3, bit 0}. Only bits 0, 3 and 6 are writable. With defaults, a write of all ones reads back 0x5A3C2049, and the reset value is 0x5A3C2000.
- R8: The selector (address 1, bits 4:0) routes the value-low (address 9), value-high (address 10) and type (address 11) accesses. Index 31 is the 64-bit cycle counter. An event counter's value-high reads 0.
- R9: For a selector index that is neither below the counter count nor 31, value and type reads return 0, and writes change no counter.
- R10: The type register holds the event number in bits 15:0. Number 0 selects software increment, and number k (1..number of event lines) selects `evt_in[k-1]`. Bits 31:26 are stored and read back but change nothing about counting.
- R11: Writing a mask to the software-increment register (address 8) adds one to each enabled counter whose mask bit is set and whose event number is 0.
- R12: An event counter that wraps from 0xFFFFFFFF goes to 0 and sets its bit in overflow-status. Overflow-status is set by write-one at address 6 and cleared by write-one at address 7, only for implemented bits. Both addresses read the status.
- R13: Interrupt-enable has write-one-to-set at address 4 and write-one-to-clear at address 5. `irq` is high exactly while some status bit and its interrupt-enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| evt_in | input | NUM_EVT | Event lines, one increment per clock high |
| irq | output | 1 | Level overflow interrupt |

## Verification
The assertions check, on every cycle, the following rules:
- A counter that is neither enabled nor written holds its value.
- Each reset action leaves its counters at zero on the next clock.
- A wrap leaves zero behind and lands in the status register.
- In the prescaled state, the cycle count is still between remainder ticks.

Only the directed scenarios can show the following:
- the exact counts reached under different enable and event patterns,
- the control read layout and write mask,
- the routing of the selector to missing and cycle indices,
- the software-increment mask,
- the 1-in-64 rate,
- which of the two overflow widths raises the cycle status bit.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
    localparam logic [ADDR_W-1:0] A_SEL     = 4'd1;
    localparam logic [ADDR_W-1:0] A_CEN_SET = 4'd2;
    localparam logic [ADDR_W-1:0] A_CEN_CLR = 4'd3;
    localparam logic [ADDR_W-1:0] A_IEN_SET = 4'd4;
    localparam logic [ADDR_W-1:0] A_IEN_CLR = 4'd5;
    localparam logic [ADDR_W-1:0] A_OVF_SET = 4'd6;
    localparam logic [ADDR_W-1:0] A_OVF_CLR = 4'd7;
    localparam logic [ADDR_W-1:0] A_SWINC   = 4'd8;
    localparam logic [ADDR_W-1:0] A_VAL_LO  = 4'd9;
    localparam logic [ADDR_W-1:0] A_VAL_HI  = 4'd10;
    localparam logic [ADDR_W-1:0] A_TYPE    = 4'd11;

    localparam int CB_EN    = 0;
    localparam int CB_EVRST = 1;
    localparam int CB_CYRST = 2;
    localparam int CB_DIV   = 3;
    localparam int CB_LONG  = 6;

    localparam int          CYC_IDX    = 31;
    localparam logic [15:0] SWINC_CODE = 16'd0;

    typedef enum logic [1:0] {
        CYC_HALT     = 2'd0,
        CYC_FULL     = 2'd1,
        CYC_PRESCALE = 2'd2
    } cyc_state_t;

endpackage

// File: rtl/pmu_evt_ctr.sv
module pmu_evt_ctr
    import pmu_pkg::*;
#(
    parameter int NUM_EVT = 4,
    parameter int CNT_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_ok,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic             swinc_hit,
    input  logic             clr,
    input  logic             val_we,
    input  logic [CNT_W-1:0] val_data,
    input  logic             type_we,
    input  logic [15:0]      type_num,
    input  logic [5:0]       type_filt,
    output logic [CNT_W-1:0] value,
    output logic [31:0]      type_rd,
    output logic             ovf_pulse
);

    logic [CNT_W-1:0] cnt_q;
    logic [15:0]      evnum_q;
    logic [5:0]       filt_q;
    logic             hit;
    logic             inc;

    always_comb begin
        hit = 1'b0;
        if (evnum_q == SWINC_CODE) begin
            hit = swinc_hit;
        end else begin
            for (int k = 0; k < NUM_EVT; k++) begin
                if (evnum_q == 16'(k + 1)) hit = evt_in[k];
            end
        end
    end

    assign inc       = count_ok & hit;
    assign ovf_pulse = inc & (&cnt_q) & ~clr & ~val_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (val_we) begin
            cnt_q <= val_data;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evnum_q <= SWINC_CODE;
            filt_q  <= '0;
        end else if (type_we) begin
            evnum_q <= type_num;
            filt_q  <= type_filt;
        end
    end

    assign value   = cnt_q;
    assign type_rd = {filt_q, 10'd0, evnum_q};

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_ok && !clr && !val_we) |=> $stable(cnt_q));

    p_evrst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    p_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> (cnt_q == '0));

endmodule

// File: rtl/pmu_cyc_ctr.sv
module pmu_cyc_ctr
    import pmu_pkg::*;
#(
    parameter int PRE_W = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        divide,
    input  logic        long_mode,
    input  logic        clr,
    input  logic        lo_we,
    input  logic        hi_we,
    input  logic [31:0] wdata,
    output logic [63:0] value,
    output logic        ovf_pulse
);

    cyc_state_t       state_q, state_d;
    logic [PRE_W-1:0] rem_q;
    logic [63:0]      val_q, val_d;
    logic             tick;
    logic             any_wr;

    always_comb begin
        unique case (state_q)
            CYC_HALT, CYC_FULL, CYC_PRESCALE: begin
                if (!run)        state_d = CYC_HALT;
                else if (divide) state_d = CYC_PRESCALE;
                else             state_d = CYC_FULL;
            end
            default: state_d = CYC_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CYC_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            CYC_FULL:     tick = 1'b1;
            CYC_PRESCALE: tick = &rem_q;
            default:      tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      rem_q <= '0;
        else if (clr)                    rem_q <= '0;
        else if (state_q == CYC_PRESCALE) rem_q <= rem_q + 1'b1;
    end

    assign any_wr = clr | lo_we | hi_we;

    always_comb begin
        val_d = val_q + 64'(tick);
        if (lo_we) val_d[31:0]  = wdata;
        if (hi_we) val_d[63:32] = wdata;
        if (clr)   val_d        = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign ovf_pulse = tick & ~any_wr & (long_mode ? (&val_q) : (&val_q[31:0]));
    assign value     = val_q;

    p_halt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CYC_HALT && !any_wr) |=> $stable(val_q));

    p_prescale_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CYC_PRESCALE && !(&rem_q) && !any_wr) |=> $stable(val_q));

    p_cycrst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (val_q == 64'd0));

    p_long_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (long_mode && ovf_pulse) |=> (val_q == 64'd0));

endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
    import pmu_pkg::*;
#(
    parameter int          NUM_CTRS  = 4,
    parameter int          NUM_EVT   = 4,
    parameter logic [7:0]  IMPL_CODE = 8'h5A,
    parameter logic [7:0]  ID_CODE   = 8'h3C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [3:0]         addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               irq
);

    localparam logic [31:0] VMASK = 32'h8000_0000 | ((32'd1 << NUM_CTRS) - 32'd1);

    logic        ctl_en, ctl_div, ctl_long;
    logic [4:0]  sel_q;
    logic [31:0] cen_q, ien_q, ovf_q;
    logic [5:0]  cyc_filt_q;

    logic wr_ctrl, wr_sel, wr_swinc, wr_vlo, wr_vhi, wr_type;
    logic wr_cens, wr_cenc, wr_iens, wr_ienc, wr_ovfs, wr_ovfc;
    logic ev_rst, cy_rst, cyc_sel, sel_valid;

    logic [31:0]         ev_val  [NUM_CTRS];
    logic [31:0]         ev_type [NUM_CTRS];
    logic [NUM_CTRS-1:0] ev_ovf;
    logic [63:0]         cyc_val;
    logic                cyc_ovf;
    logic [31:0]         ovf_hw;
    logic [31:0]         sel_val, sel_type;

    assign wr_ctrl  = wr_en && addr == A_CTRL;
    assign wr_sel   = wr_en && addr == A_SEL;
    assign wr_cens  = wr_en && addr == A_CEN_SET;
    assign wr_cenc  = wr_en && addr == A_CEN_CLR;
    assign wr_iens  = wr_en && addr == A_IEN_SET;
    assign wr_ienc  = wr_en && addr == A_IEN_CLR;
    assign wr_ovfs  = wr_en && addr == A_OVF_SET;
    assign wr_ovfc  = wr_en && addr == A_OVF_CLR;
    assign wr_swinc = wr_en && addr == A_SWINC;
    assign wr_vlo   = wr_en && addr == A_VAL_LO;
    assign wr_vhi   = wr_en && addr == A_VAL_HI;
    assign wr_type  = wr_en && addr == A_TYPE;

    assign ev_rst    = wr_ctrl & wdata[CB_EVRST];
    assign cy_rst    = wr_ctrl & wdata[CB_CYRST];
    assign cyc_sel   = sel_q == 5'(CYC_IDX);
    assign sel_valid = sel_q < 5'(NUM_CTRS);

    generate
        for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
            pmu_evt_ctr #(.NUM_EVT(NUM_EVT), .CNT_W(32)) u_ctr (
                .clk       (clk),
                .rst_n     (rst_n),
                .count_ok  (ctl_en & cen_q[i]),
                .evt_in    (evt_in),
                .swinc_hit (wr_swinc & wdata[i]),
                .clr       (ev_rst),
                .val_we    (wr_vlo && sel_q == 5'(i)),
                .val_data  (wdata),
                .type_we   (wr_type && sel_q == 5'(i)),
                .type_num  (wdata[15:0]),
                .type_filt (wdata[31:26]),
                .value     (ev_val[i]),
                .type_rd   (ev_type[i]),
                .ovf_pulse (ev_ovf[i])
            );
        end
    endgenerate

    pmu_cyc_ctr #(.PRE_W(6)) u_cyc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctl_en & cen_q[CYC_IDX]),
        .divide    (ctl_div),
        .long_mode (ctl_long),
        .clr       (cy_rst),
        .lo_we     (wr_vlo & cyc_sel),
        .hi_we     (wr_vhi & cyc_sel),
        .wdata     (wdata),
        .value     (cyc_val),
        .ovf_pulse (cyc_ovf)
    );

    always_comb begin
        ovf_hw = '0;
        for (int i = 0; i < NUM_CTRS; i++) ovf_hw[i] = ev_ovf[i];
        ovf_hw[CYC_IDX] = cyc_ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en     <= 1'b0;
            ctl_div    <= 1'b0;
            ctl_long   <= 1'b0;
            sel_q      <= '0;
            cen_q      <= '0;
            ien_q      <= '0;
            ovf_q      <= '0;
            cyc_filt_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctl_en   <= wdata[CB_EN];
                ctl_div  <= wdata[CB_DIV];
                ctl_long <= wdata[CB_LONG];
            end
            if (wr_sel)  sel_q <= wdata[4:0];
            if (wr_cens) cen_q <= cen_q | (wdata & VMASK);
            if (wr_cenc) cen_q <= cen_q & ~wdata;
            if (wr_iens) ien_q <= ien_q | (wdata & VMASK);
            if (wr_ienc) ien_q <= ien_q & ~wdata;
            ovf_q <= ((ovf_q | (wr_ovfs ? (wdata & VMASK) : 32'd0))
                     & ~(wr_ovfc ? wdata : 32'd0)) | ovf_hw;
            if (wr_type && cyc_sel) cyc_filt_q <= wdata[31:26];
        end
    end

    always_comb begin
        sel_val  = '0;
        sel_type = '0;
        for (int i = 0; i < NUM_CTRS; i++) begin
            if (sel_q == 5'(i)) begin
                sel_val  = ev_val[i];
                sel_type = ev_type[i];
            end
        end
        if (cyc_sel) begin
            sel_val  = cyc_val[31:0];
            sel_type = {cyc_filt_q, 26'd0};
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:               rdata = {IMPL_CODE, ID_CODE, 5'(NUM_CTRS), 4'd0,
                                           ctl_long, 2'd0, ctl_div, 2'd0, ctl_en};
            A_SEL:                rdata = {27'd0, sel_q};
            A_CEN_SET, A_CEN_CLR: rdata = cen_q;
            A_IEN_SET, A_IEN_CLR: rdata = ien_q;
            A_OVF_SET, A_OVF_CLR: rdata = ovf_q;
            A_VAL_LO:             rdata = sel_val;
            A_VAL_HI:             rdata = cyc_sel ? cyc_val[63:32] : 32'd0;
            A_TYPE:               rdata = sel_type;
            default:              rdata = 32'd0;
        endcase
    end

    assign irq = |(ovf_q & ien_q);

    p_ovfset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_hw != 32'd0) |=> ((ovf_q & $past(ovf_hw)) == $past(ovf_hw)));

    p_missing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_valid && !cyc_sel && (addr == A_VAL_LO || addr == A_TYPE)) |-> (rdata == 32'd0));

    p_irqclr_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ienc && wdata == 32'hFFFF_FFFF) |=> !irq);

endmodule

// File: tb/perf_mon_unit_bench.sv
module perf_mon_unit_bench;
    import pmu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NEVT       = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [3:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NEVT-1:0] evt_in = '0;
    logic            irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    perf_mon_unit #(.NUM_CTRS(4), .NUM_EVT(NEVT), .IMPL_CODE(8'h5A), .ID_CODE(8'h3C))
    u_perf_mon_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .evt_in(evt_in), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rd_ctr(input logic [4:0] idx, output logic [31:0] d);
        wr(A_SEL, {27'd0, idx});
        rd(A_VAL_LO, d);
    endtask

    task automatic pulse(input int line, input int n);
        @(negedge clk);
        evt_in[line] = 1'b1;
        repeat (n) @(negedge clk);
        evt_in[line] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v);    check("R7 reset control", v, 32'h5A3C2000);
        rd(A_OVF_SET, v); check("R12 reset status", v, 32'd0);
        rd(A_CEN_SET, v); check("R2 reset enables", v, 32'd0);
        check("R13 reset irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_ctrl_mask();
        logic [31:0] v;
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); check("R7 write mask", v, 32'h5A3C2049);
        wr(A_CTRL, 32'd0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        wr(A_SEL, 0); wr(A_TYPE, 1);
        wr(A_SEL, 1); wr(A_TYPE, 2);
        wr(A_CEN_SET, 32'h3);
        rd(A_CEN_SET, v); check("R2 enable set", v, 32'h3);
        wr(A_CTRL, 32'h1);
        pulse(0, 5); pulse(1, 3);
        rd_ctr(0, v); check("R10 event line 0 count", v, 5);
        rd_ctr(1, v); check("R10 event line 1 count", v, 3);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        wr(A_CTRL, 32'd0);
        pulse(0, 4);
        rd_ctr(0, v); check("R1 global disable", v, 5);
        wr(A_CTRL, 32'h1);
        wr(A_CEN_CLR, 32'h1);
        pulse(0, 4); pulse(1, 2);
        rd_ctr(0, v); check("R2 counter disabled", v, 5);
        rd_ctr(1, v); check("R1 enabled counter", v, 5);
        rd(A_CEN_CLR, v); check("R2 enable clear", v, 32'h2);
    endtask

    task automatic t_resets();
        logic [31:0] v;
        wr(A_SEL, 31); wr(A_VAL_LO, 32'h1234);
        wr(A_CTRL, 32'h3);
        rd_ctr(31, v); check("R3 cycle kept", v, 32'h1234);
        rd_ctr(1, v);  check("R3 events zeroed", v, 0);
        rd(A_CTRL, v); check("R3 one-shot reads 0", v & 32'h6, 0);
        wr(A_CTRL, 32'h5);
        rd_ctr(31, v); check("R4 cycle zeroed", v, 0);
    endtask

    task automatic t_swinc();
        logic [31:0] v;
        wr(A_CEN_SET, 32'hF);
        wr(A_SWINC, 32'h5);
        rd_ctr(0, v); check("R11 non-swinc type ignored", v, 0);
        rd_ctr(2, v); check("R11 masked increment", v, 1);
        rd_ctr(3, v); check("R11 unmasked counter", v, 0);
        wr(A_SWINC, 32'h8);
        rd_ctr(3, v); check("R11 second mask", v, 1);
    endtask

    task automatic t_missing();
        logic [31:0] v;
        wr(A_SEL, 5); wr(A_VAL_LO, 32'hDEAD); wr(A_TYPE, 1);
        rd(A_VAL_LO, v); check("R9 missing value", v, 0);
        rd(A_TYPE, v);   check("R9 missing type", v, 0);
        rd_ctr(2, v); check("R9 write ignored c2", v, 1);
        rd_ctr(3, v); check("R9 write ignored c3", v, 1);
        rd(A_VAL_HI, v); check("R8 event high word", v, 0);
    endtask

    task automatic t_filter();
        logic [31:0] v;
        wr(A_SEL, 0); wr(A_TYPE, 32'hFC00_0001);
        rd(A_TYPE, v); check("R10 filter stored", v, 32'hFC00_0001);
        pulse(0, 2);
        rd_ctr(0, v); check("R10 filter no effect", v, 2);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        wr(A_SEL, 0); wr(A_VAL_LO, 32'hFFFF_FFFF);
        pulse(0, 1);
        rd(A_VAL_LO, v);  check("R12 wrap to zero", v, 0);
        rd(A_OVF_SET, v); check("R12 status set", v, 32'h1);
        check("R13 irq masked", {31'd0, irq}, 0);
        wr(A_IEN_SET, 32'h1);
        check("R13 irq raised", {31'd0, irq}, 1);
        wr(A_OVF_CLR, 32'h1);
        check("R13 irq dropped", {31'd0, irq}, 0);
        wr(A_OVF_SET, 32'h8000_0010);
        rd(A_OVF_CLR, v); check("R12 set implemented only", v, 32'h8000_0000);
        check("R13 other enable", {31'd0, irq}, 0);
        wr(A_IEN_SET, 32'h8000_0000);
        check("R13 cycle bit irq", {31'd0, irq}, 1);
        wr(A_OVF_CLR, 32'hFFFF_FFFF);
        wr(A_IEN_CLR, 32'hFFFF_FFFF);
        check("R13 all clear", {31'd0, irq}, 0);
    endtask

    task automatic t_cycle();
        logic [31:0] a, b;
        wr(A_CEN_SET, 32'h8000_0000);
        wr(A_CTRL, 32'h1);
        wr(A_SEL, 31);
        repeat (3) @(negedge clk);
        rd(A_VAL_LO, a);
        repeat (100) @(negedge clk);
        rd(A_VAL_LO, b); check("R5 full rate", b - a, 100);
        wr(A_CTRL, 32'h9);
        repeat (4) @(negedge clk);
        rd(A_VAL_LO, a);
        repeat (640) @(negedge clk);
        rd(A_VAL_LO, b); check("R5 divide by 64", b - a, 10);
        wr(A_CTRL, 32'h0);
        repeat (3) @(negedge clk);
        rd(A_VAL_LO, a);
        repeat (20) @(negedge clk);
        rd(A_VAL_LO, b); check("R1 cycle halted", b, a);
    endtask

    task automatic t_long();
        logic [31:0] v;
        wr(A_CTRL, 32'h1);
        wr(A_SEL, 31);
        wr(A_VAL_HI, 0); wr(A_VAL_LO, 32'hFFFF_FFF0);
        repeat (40) @(negedge clk);
        rd(A_OVF_SET, v); check("R6 short wrap flags", v, 32'h8000_0000);
        rd(A_VAL_HI, v);  check("R6 carry to high", v, 1);
        wr(A_OVF_CLR, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h41);
        wr(A_VAL_HI, 0); wr(A_VAL_LO, 32'hFFFF_FFF0);
        repeat (40) @(negedge clk);
        rd(A_OVF_SET, v); check("R6 long no flag", v, 0);
        rd(A_VAL_HI, v);  check("R6 long carry", v, 1);
        wr(A_VAL_HI, 32'hFFFF_FFFF); wr(A_VAL_LO, 32'hFFFF_FFF0);
        repeat (40) @(negedge clk);
        rd(A_OVF_SET, v); check("R6 long wrap flags", v, 32'h8000_0000);
        rd(A_VAL_HI, v);  check("R8 full wrap high", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_mask();
        t_count();
        t_gate();
        t_resets();
        t_swinc();
        t_missing();
        t_filter();
        t_overflow();
        t_cycle();
        t_long();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule